// File: doc/BRIEF.md
# Per-Port LED Configuration Register Bank

This block holds the LED configuration of up to six switch ports. A host agent changes it with one 16-bit command word at a time. The word carries three things: a commit flag, a 3-bit target code that names one of several hidden sub-registers, and an 11-bit payload. A separate port index and a single-cycle write strobe go with the word. The block decodes the command, loads the payload into the named sub-register of the named port, and presents every stored value in parallel on registered outputs for the LED drive logic.

The block has no read path. The agent must therefore keep its own shadow of each port's settings and send whole fields every time. The block quietly drops any command that is not a complete, legal update: a missing strobe, a clear commit flag, an unused target code, or a port without LEDs. It raises no error in any of these cases.

Top module: `led_cfg_port`

## Requirements
- R1: While `rst` is high at a clock edge, every port returns to its defaults after that edge. Both LED selectors become 0 (link/activity). The blink code becomes 3 (168 ms; codes 0..5 mean 21, 42, 84, 168, 336 and 672 ms). The stretch code becomes 0 (none). The special word becomes 0.
- R2: A command whose bit 15 (commit flag) is 0 changes no stored value.
- R3: A committed command with target code 0 (bits 14:12) loads payload bits 3:0 into the first LED selector and bits 7:4 into the second LED selector of the addressed port.
- R4: A committed command with target code 6 loads payload bits 2:0 into the blink code and bits 6:4 into the stretch code of the addressed port.
- R5: A committed command with target code 7 loads payload bits 6:0 into the special-LED word of the addressed port.
- R6: Commands with target codes 1 to 5 change no stored value.
- R7: Commands addressed to a port index of 6 or above (outside 0..NUM_PORTS-1) change no stored value.
- R8: A command word presented while `wr_en` is low changes no stored value.
- R9: A legal command appears on the outputs right after the clock edge at which `wr_en` is sampled high. There is no further delay.
- R10: A legal command changes only the sub-register it targets on the port it addresses. The other sub-registers of that port and all other ports hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle command strobe |
| wr_port | input | PORT_IDX_W (4) | Port index the command targets |
| wr_word | input | 16 | Command: [15] commit, [14:12] target, [11] unused, [10:0] payload |
| led0_sel_o | output | NUM_PORTS*4 | First LED selector per port, port p at [4p+3:4p] |
| led1_sel_o | output | NUM_PORTS*4 | Second LED selector per port |
| blink_o | output | NUM_PORTS*3 | Blink-rate code per port |
| stretch_o | output | NUM_PORTS*3 | Pulse-stretch code per port |
| special_o | output | NUM_PORTS*7 | Special-LED word per port |

## Verification
Each stored value is exactly one register away from the command inputs. A command applied before a rising edge is therefore due on the outputs just after that same edge, and a reset is due after the first edge that samples `rst` high. The bench changes its inputs on falling edges and compares every port's outputs with its own shadow model at the next falling edge. That point is half a cycle after the capturing edge and before any later command can land. Commands that must be dropped are checked the same way: every field of every port is compared with the unchanged shadow.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;

  localparam int CMD_W     = 16;
  localparam int TARGET_W  = 3;
  localparam int PAYLOAD_W = 11;
  localparam int SEL_W     = 4;
  localparam int RATE_W    = 3;
  localparam int SPEC_W    = 7;

  // Command word layout, MSB first
  typedef struct packed {
    logic                 commit;
    logic [TARGET_W-1:0]  target;
    logic                 spare;
    logic [PAYLOAD_W-1:0] payload;
  } led_cmd_t;

  localparam logic [TARGET_W-1:0] TGT_SELECT  = 3'd0;
  localparam logic [TARGET_W-1:0] TGT_TIMING  = 3'd6;
  localparam logic [TARGET_W-1:0] TGT_SPECIAL = 3'd7;

  // Reset defaults
  localparam logic [SEL_W-1:0]  SEL_DEFAULT     = 4'd0;
  localparam logic [RATE_W-1:0] BLINK_DEFAULT   = 3'd3;
  localparam logic [RATE_W-1:0] STRETCH_DEFAULT = 3'd0;
  localparam logic [SPEC_W-1:0] SPEC_DEFAULT    = 7'd0;

endpackage

// File: rtl/led_cfg_decode.sv
module led_cfg_decode
  import led_cfg_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_IDX_W = 4
) (
  input  logic                  wr_en,
  input  logic [PORT_IDX_W-1:0] wr_port,
  input  logic [CMD_W-1:0]      wr_word,
  output logic [NUM_PORTS-1:0]  we_select,
  output logic [NUM_PORTS-1:0]  we_timing,
  output logic [NUM_PORTS-1:0]  we_special,
  output logic [PAYLOAD_W-1:0]  payload
);

  localparam logic [PORT_IDX_W:0] PORT_LIMIT = (PORT_IDX_W+1)'(NUM_PORTS);

  led_cmd_t cmd;
  logic     legal;
  logic     tgt_sel, tgt_tim, tgt_spc;

  always_comb begin
    cmd     = led_cmd_t'(wr_word);
    payload = cmd.payload;
    legal   = wr_en && cmd.commit && ({1'b0, wr_port} < PORT_LIMIT);
    tgt_sel = legal && (cmd.target == TGT_SELECT);
    tgt_tim = legal && (cmd.target == TGT_TIMING);
    tgt_spc = legal && (cmd.target == TGT_SPECIAL);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_hit
    logic hit;
    assign hit           = (wr_port == PORT_IDX_W'(p));
    assign we_select[p]  = hit && tgt_sel;
    assign we_timing[p]  = hit && tgt_tim;
    assign we_special[p] = hit && tgt_spc;
  end

endmodule

// File: rtl/led_cfg_bank.sv
module led_cfg_bank
  import led_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_select,
  input  logic                 we_timing,
  input  logic                 we_special,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [SEL_W-1:0]     led0_sel,
  output logic [SEL_W-1:0]     led1_sel,
  output logic [RATE_W-1:0]    blink,
  output logic [RATE_W-1:0]    stretch,
  output logic [SPEC_W-1:0]    special
);

  always_ff @(posedge clk) begin
    if (rst) begin
      led0_sel <= SEL_DEFAULT;
      led1_sel <= SEL_DEFAULT;
    end else if (we_select) begin
      led0_sel <= payload[SEL_W-1:0];
      led1_sel <= payload[2*SEL_W-1:SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blink   <= BLINK_DEFAULT;
      stretch <= STRETCH_DEFAULT;
    end else if (we_timing) begin
      blink   <= payload[RATE_W-1:0];
      stretch <= payload[4+RATE_W-1:4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             special <= SPEC_DEFAULT;
    else if (we_special) special <= payload[SPEC_W-1:0];
  end

endmodule

// File: rtl/led_cfg_port.sv
module led_cfg_port
  import led_cfg_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [PORT_IDX_W-1:0]       wr_port,
  input  logic [CMD_W-1:0]            wr_word,
  output logic [NUM_PORTS*SEL_W-1:0]  led0_sel_o,
  output logic [NUM_PORTS*SEL_W-1:0]  led1_sel_o,
  output logic [NUM_PORTS*RATE_W-1:0] blink_o,
  output logic [NUM_PORTS*RATE_W-1:0] stretch_o,
  output logic [NUM_PORTS*SPEC_W-1:0] special_o
);

  logic [NUM_PORTS-1:0] we_select, we_timing, we_special;
  logic [PAYLOAD_W-1:0] payload;

  led_cfg_decode #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_IDX_W(PORT_IDX_W)
  ) u_decode (
    .wr_en     (wr_en),
    .wr_port   (wr_port),
    .wr_word   (wr_word),
    .we_select (we_select),
    .we_timing (we_timing),
    .we_special(we_special),
    .payload   (payload)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    led_cfg_bank u_bank (
      .clk       (clk),
      .rst       (rst),
      .we_select (we_select[p]),
      .we_timing (we_timing[p]),
      .we_special(we_special[p]),
      .payload   (payload),
      .led0_sel  (led0_sel_o[p*SEL_W +: SEL_W]),
      .led1_sel  (led1_sel_o[p*SEL_W +: SEL_W]),
      .blink     (blink_o[p*RATE_W +: RATE_W]),
      .stretch   (stretch_o[p*RATE_W +: RATE_W]),
      .special   (special_o[p*SPEC_W +: SPEC_W])
    );
  end

endmodule

// File: rtl/led_cfg_port_chk.sv
module led_cfg_port_chk
  import led_cfg_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int PORT_IDX_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic [PORT_IDX_W-1:0]       wr_port,
  input logic [CMD_W-1:0]            wr_word,
  input logic [NUM_PORTS*SEL_W-1:0]  led0_sel_o,
  input logic [NUM_PORTS*SEL_W-1:0]  led1_sel_o,
  input logic [NUM_PORTS*RATE_W-1:0] blink_o,
  input logic [NUM_PORTS*RATE_W-1:0] stretch_o,
  input logic [NUM_PORTS*SPEC_W-1:0] special_o
);

  localparam logic [PORT_IDX_W:0] PORT_LIMIT = (PORT_IDX_W+1)'(NUM_PORTS);

  logic in_range, committed, all_same_next;
  assign in_range  = ({1'b0, wr_port} < PORT_LIMIT);
  assign committed = wr_en && wr_word[15];

  // R1
  reset_default_chk: assert property (@(posedge clk)
    rst |=> (led0_sel_o == '0) && (led1_sel_o == '0) && (special_o == '0) &&
            (blink_o == {NUM_PORTS{BLINK_DEFAULT}}) && (stretch_o == '0));

  // R2 R8
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !committed |=> $stable(led0_sel_o) && $stable(led1_sel_o) &&
                   $stable(blink_o) && $stable(stretch_o) && $stable(special_o));

  // R6
  unused_target_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_word[14:12] != 3'd0 && wr_word[14:12] < 3'd6) |=>
      $stable(led0_sel_o) && $stable(led1_sel_o) &&
      $stable(blink_o) && $stable(stretch_o) && $stable(special_o));

  // R7
  bad_port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_range |=> $stable(led0_sel_o) && $stable(led1_sel_o) &&
                  $stable(blink_o) && $stable(stretch_o) && $stable(special_o));

  // R3 R9
  select_load_chk: assert property (@(posedge clk) disable iff (rst)
    (committed && in_range && wr_word[14:12] == 3'd0) |=>
      (led0_sel_o[SEL_W*int'($past(wr_port)) +: SEL_W] == $past(wr_word[3:0])) &&
      (led1_sel_o[SEL_W*int'($past(wr_port)) +: SEL_W] == $past(wr_word[7:4])));

  // R10
  select_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    (committed && wr_word[14:12] == 3'd0) |=>
      $stable(blink_o) && $stable(stretch_o) && $stable(special_o));

  // R4
  timing_load_chk: assert property (@(posedge clk) disable iff (rst)
    (committed && in_range && wr_word[14:12] == 3'd6) |=>
      (blink_o[RATE_W*int'($past(wr_port)) +: RATE_W] == $past(wr_word[2:0])) &&
      (stretch_o[RATE_W*int'($past(wr_port)) +: RATE_W] == $past(wr_word[6:4])));

  // R5
  special_load_chk: assert property (@(posedge clk) disable iff (rst)
    (committed && in_range && wr_word[14:12] == 3'd7) |=>
      (special_o[SPEC_W*int'($past(wr_port)) +: SPEC_W] == $past(wr_word[6:0])));

endmodule

bind led_cfg_port led_cfg_port_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_IDX_W(PORT_IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_port   (wr_port),
  .wr_word   (wr_word),
  .led0_sel_o(led0_sel_o),
  .led1_sel_o(led1_sel_o),
  .blink_o   (blink_o),
  .stretch_o (stretch_o),
  .special_o (special_o)
);

// File: tb/led_cfg_port_bench.sv
module led_cfg_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 6;
  localparam int PW         = 4;
  localparam int WATCHDOG   = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [PW-1:0] wr_port = '0;
  logic [15:0]   wr_word = '0;
  logic [NP*4-1:0] led0_sel_o, led1_sel_o;
  logic [NP*3-1:0] blink_o, stretch_o;
  logic [NP*7-1:0] special_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [3:0] m_sel0 [NP];
  logic [3:0] m_sel1 [NP];
  logic [2:0] m_blink [NP];
  logic [2:0] m_str [NP];
  logic [6:0] m_spec [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  led_cfg_port #(.NUM_PORTS(NP), .PORT_IDX_W(PW)) u_led_cfg_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_word(wr_word),
    .led0_sel_o(led0_sel_o), .led1_sel_o(led1_sel_o), .blink_o(blink_o),
    .stretch_o(stretch_o), .special_o(special_o)
  );

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_sel0[p] = 4'd0; m_sel1[p] = 4'd0;
      m_blink[p] = 3'd3; m_str[p] = 3'd0; m_spec[p] = 7'd0;
    end
  endtask

  // Compare every port against the shadow model
  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) begin
      logic [20:0] act, exp;
      act = {led0_sel_o[p*4 +: 4], led1_sel_o[p*4 +: 4], blink_o[p*3 +: 3],
             stretch_o[p*3 +: 3], special_o[p*7 +: 7]};
      exp = {m_sel0[p], m_sel1[p], m_blink[p], m_str[p], m_spec[p]};
      n_chk++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s port %0d actual %h expected %h", req, p, act, exp);
      end
    end
  endtask

  // Drive one command at a falling edge, sample at the next falling edge
  task automatic send(input logic en, input logic [PW-1:0] port, input logic commit,
                      input logic [2:0] tgt, input logic [10:0] data, input string req);
    wr_en   = en;
    wr_port = port;
    wr_word = {commit, tgt, 1'b0, data};
    if (en && commit && port < PW'(NP)) begin
      case (tgt)
        3'd0: begin m_sel0[port] = data[3:0]; m_sel1[port] = data[7:4]; end
        3'd6: begin m_blink[port] = data[2:0]; m_str[port] = data[6:4]; end
        3'd7: m_spec[port] = data[6:0];
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    wr_word = '0;
    check_all(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    check_all("R1");
    rst = 1'b0;
  endtask

  task automatic t_select();
    send(1'b1, 4'd0, 1'b1, 3'd0, 11'h7A5, "R3 R9");
    send(1'b1, 4'd5, 1'b1, 3'd0, 11'h03C, "R3 R10");
    send(1'b1, 4'd2, 1'b1, 3'd0, 11'h0FF, "R3");
  endtask

  task automatic t_timing();
    send(1'b1, 4'd1, 1'b1, 3'd6, 11'h055, "R4 R10");
    send(1'b1, 4'd5, 1'b1, 3'd6, 11'h7F2, "R4");
  endtask

  task automatic t_special();
    send(1'b1, 4'd3, 1'b1, 3'd7, 11'h77F, "R5");
    send(1'b1, 4'd4, 1'b1, 3'd7, 11'h02A, "R5 R10");
  endtask

  task automatic t_no_commit();
    send(1'b1, 4'd0, 1'b0, 3'd0, 11'h0EE, "R2");
    send(1'b1, 4'd3, 1'b0, 3'd7, 11'h011, "R2");
  endtask

  task automatic t_unused_target();
    for (int t = 1; t <= 5; t++) send(1'b1, 4'd1, 1'b1, 3'(t), 11'h7FF, "R6");
  endtask

  task automatic t_bad_port();
    send(1'b1, 4'd6, 1'b1, 3'd0, 11'h0DD, "R7");
    send(1'b1, 4'd15, 1'b1, 3'd7, 11'h07F, "R7");
  endtask

  task automatic t_no_strobe();
    send(1'b0, 4'd2, 1'b1, 3'd6, 11'h044, "R8");
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    t_reset();
    t_select();
    t_timing();
    t_special();
    t_no_commit();
    t_unused_target();
    t_bad_port();
    t_no_strobe();
    t_reset();
    send(1'b1, 4'd4, 1'b1, 3'd0, 11'h0B9, "R3 R9");
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule